// File: doc/BRIEF.md
# Clock-Gated Moore State Machine

This block is a four-state Moore machine whose state register sits behind a latch-based clock gate. On every rising edge of the free-running clock, activation logic looks at the current state and the two-bit input. If the machine would only stay where it is (a self-loop in its transition graph), the edge is not passed to the state flip-flops. The register therefore toggles its clock pin only on edges that really change the state, or that load the clear state.

The gating cell holds the enable in a level-sensitive latch. The latch is open while the clock is low and closed while it is high, and the gated clock is the AND of the clock and the latched enable. An enable that settles late in the low phase can never shorten or split a clock pulse.

A synchronous clear overrides the gating. A wrapping counter in the ungated domain counts every suppressed edge, so a testbench can compare the gating activity with the number of self-loops it predicts.

Top module: `cg_moore_fsm`

## Requirements
- R1: The output depends only on the present state: state 0 gives 2'b00, state 1 gives 2'b01, state 2 gives 2'b11 and state 3 gives 2'b10.
- R2: In states 0, 1 and 2, with clear low, the next state is the state whose number equals the input value: input 2'b00 goes to state 0, 2'b01 to state 1, 2'b10 to state 2 and 2'b11 to state 3.
- R3: In state 3, with clear low, the next state is state 0 whatever the input.
- R4: A clear sampled high at a clock edge puts the machine in state 0 (output 2'b00) and sets the skip counter to zero. Clear takes priority over the input and over the gating.
- R5: When the present state is 0, 1 or 2 and the input equals that state's number, the gated clock produces no edge and the state holds.
- R6: The skip counter adds one, wrapping modulo 2^COUNT_W, on each edge where the state clock is suppressed. It keeps its value on every other edge that does not clear it.
- R7: For any input stream, the output sequence matches that of the same transition table clocked without gating, cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; rising edge active |
| clr | input | 1 | Synchronous clear, active high |
| in_sel | input | 2 | Primary input that selects the next state |
| out_code | output | 2 | Moore output decoded from the state |
| gated_cnt | output | COUNT_W | Number of suppressed state-clock edges since clear, wrapping |

## Verification
The hardest situations to reach from the ports are a counter wrap caused only by long self-loop runs, and a clear that arrives on a cycle whose input would otherwise be a self-loop. In that second case the forced enable must win and the counter must not step. The bench builds the block with a narrow counter and holds one input long enough to wrap it. It also applies clear while the input matches the current state, and it mixes random clears into a long seeded random stream. That stream covers every state-input pair next to the directed runs through state 3.

// File: rtl/cg_fsm_pkg.sv
package cg_fsm_pkg;

    typedef enum logic [1:0] {
        ST_S0 = 2'd0,
        ST_S1 = 2'd1,
        ST_S2 = 2'd2,
        ST_S3 = 2'd3
    } fsm_st_e;

    typedef struct packed {
        fsm_st_e state;
    } state_reg_t;

    // Moore output code for each state
    function automatic logic [1:0] out_of_state(input fsm_st_e st);
        case (st)
            ST_S0:   return 2'b00;
            ST_S1:   return 2'b01;
            ST_S2:   return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/cg_fsm_next.sv
module cg_fsm_next
    import cg_fsm_pkg::*;
(
    input  logic        clr,
    input  logic [1:0]  sel,
    input  fsm_st_e     state_q,
    output fsm_st_e     state_d,
    output logic        clk_en
);
    fsm_st_e nxt;

    always_comb begin
        // transition table, ignoring clear
        if (state_q == ST_S3) begin
            nxt = ST_S0;
        end else begin
            nxt = fsm_st_e'(sel);
        end
        state_d = clr ? ST_S0 : nxt;
        // activation: clock only on a real change, or when clear forces a load
        clk_en  = clr | (nxt != state_q);
    end

endmodule

// File: rtl/cg_clock_gate.sv
module cg_clock_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // open while clock is low, frozen through the high phase
    always_latch begin
        if (!clk) begin
            en_lat <= en;
        end
    end

    assign gclk = clk & en_lat;

endmodule

// File: rtl/cg_fsm_state.sv
module cg_fsm_state
    import cg_fsm_pkg::*;
(
    input  logic        gclk,
    input  fsm_st_e     state_d,
    output fsm_st_e     state_q,
    output logic [1:0]  out_code
);
    state_reg_t reg_d;
    state_reg_t reg_q;

    always_comb begin
        reg_d.state = state_d;
    end

    always_ff @(posedge gclk) begin
        reg_q <= reg_d;
    end

    assign state_q  = reg_q.state;
    assign out_code = out_of_state(reg_q.state);

endmodule

// File: rtl/cg_skip_counter.sv
module cg_skip_counter #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               skip,
    output logic [COUNT_W-1:0] cnt
);
    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t cnt_d;
    cnt_reg_t cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d.cnt = '0;
        end else if (skip) begin
            cnt_d.cnt = cnt_q.cnt + COUNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q.cnt;

endmodule

// File: rtl/cg_moore_fsm.sv
module cg_moore_fsm
    import cg_fsm_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               clr,
    input  logic [1:0]         in_sel,
    output logic [1:0]         out_code,
    output logic [COUNT_W-1:0] gated_cnt
);
    fsm_st_e state_q;
    fsm_st_e state_d;
    logic    clk_en;
    logic    gclk;

    cg_fsm_next i_next (
        .clr     (clr),
        .sel     (in_sel),
        .state_q (state_q),
        .state_d (state_d),
        .clk_en  (clk_en)
    );

    cg_clock_gate i_gate (
        .clk  (clk),
        .en   (clk_en),
        .gclk (gclk)
    );

    cg_fsm_state i_state (
        .gclk     (gclk),
        .state_d  (state_d),
        .state_q  (state_q),
        .out_code (out_code)
    );

    cg_skip_counter #(.COUNT_W(COUNT_W)) i_skip (
        .clk  (clk),
        .clr  (clr),
        .skip (~clk_en),
        .cnt  (gated_cnt)
    );

endmodule

// File: rtl/cg_moore_fsm_chk.sv
module cg_moore_fsm_chk
    import cg_fsm_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input logic               clk,
    input logic               clr,
    input logic [1:0]         in_sel,
    input logic [1:0]         out_code,
    input logic [COUNT_W-1:0] gated_cnt,
    input fsm_st_e            state_q
);
    logic loop_now;
    assign loop_now = (state_q != ST_S3) && (in_sel == 2'(state_q));

    AST_MOORE_OUT: assert property (@(posedge clk) disable iff (clr)
        $stable(state_q) |-> $stable(out_code)); // R1

    AST_TAKE_INPUT: assert property (@(posedge clk) disable iff (clr)
        (state_q != ST_S3 && !loop_now) |=> (2'(state_q) == $past(in_sel))); // R2

    AST_S3_RETURN: assert property (@(posedge clk) disable iff (clr)
        (state_q == ST_S3) |=> (state_q == ST_S0)); // R3

    AST_CLR_LOAD: assert property (@(posedge clk)
        clr |=> (state_q == ST_S0 && out_code == 2'b00 && gated_cnt == '0)); // R4

    AST_HOLD_LOOP: assert property (@(posedge clk) disable iff (clr)
        loop_now |=> $stable(state_q)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (clr)
        loop_now |=> (gated_cnt == COUNT_W'($past(gated_cnt) + 1'b1))); // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (clr)
        !loop_now |=> $stable(gated_cnt)); // R6

endmodule

bind cg_moore_fsm cg_moore_fsm_chk #(.COUNT_W(COUNT_W)) i_chk (
    .clk       (clk),
    .clr       (clr),
    .in_sel    (in_sel),
    .out_code  (out_code),
    .gated_cnt (gated_cnt),
    .state_q   (state_q)
);

// File: tb/test_cg_moore_fsm.sv
module test_cg_moore_fsm;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic [1:0]    in_sel = 2'b00;
    logic [1:0]    out_code;
    logic [CW-1:0] gated_cnt;

    int            checks = 0;
    int            errors = 0;
    logic [1:0]    m_state = 2'd0;
    logic [CW-1:0] m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cg_moore_fsm #(.COUNT_W(CW)) i_cg_moore_fsm (
        .clk       (clk),
        .clr       (clr),
        .in_sel    (in_sel),
        .out_code  (out_code),
        .gated_cnt (gated_cnt)
    );

    function automatic logic [1:0] exp_out(input logic [1:0] st);
        case (st)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            2'd2:    return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic exp_loop(input logic [1:0] st, input logic [1:0] s);
        return (st != 2'd3) && (s == st);
    endfunction

    function automatic logic [1:0] exp_next(input logic [1:0] st, input logic [1:0] s);
        return (st == 2'd3) ? 2'd0 : s;
    endfunction

    task automatic check_ports(input string tag);
        checks++;
        if (out_code !== exp_out(m_state)) begin
            errors++;
            $display("FAIL %s out_code actual=%b expected=%b", tag, out_code, exp_out(m_state));
        end
        checks++;
        if (gated_cnt !== m_cnt) begin
            errors++;
            $display("FAIL %s gated_cnt actual=%0d expected=%0d", tag, gated_cnt, m_cnt);
        end
    endtask

    // called in the low phase: drive, predict the next edge, check at next low phase
    task automatic step(input logic c, input logic [1:0] s, input string tag);
        clr    = c;
        in_sel = s;
        if (c) begin
            m_state = 2'd0;
            m_cnt   = '0;
        end else begin
            if (exp_loop(m_state, s)) m_cnt = m_cnt + 1'b1;
            m_state = exp_next(m_state, s);
        end
        @(negedge clk);
        check_ports(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20101);

        // R4: clear state
        step(1'b1, 2'b11, "R4_reset");
        step(1'b1, 2'b01, "R4_reset");

        // R5 R6: hold in state 0
        for (int i = 0; i < 5; i++) step(1'b0, 2'b00, "R5_hold_s0");
        // R2: move to 1, hold
        step(1'b0, 2'b01, "R2_s0_to_s1");
        for (int i = 0; i < 3; i++) step(1'b0, 2'b01, "R5_hold_s1");
        // R2: to 2, hold, then 2 to 3
        step(1'b0, 2'b10, "R2_s1_to_s2");
        step(1'b0, 2'b10, "R5_hold_s2");
        step(1'b0, 2'b11, "R2_s2_to_s3");
        // R3: state 3 ignores input and returns to 0
        step(1'b0, 2'b11, "R3_s3_in11");
        step(1'b0, 2'b11, "R2_s0_to_s3");
        step(1'b0, 2'b10, "R3_s3_in10");
        step(1'b0, 2'b01, "R2_s0_to_s1");
        step(1'b0, 2'b00, "R2_s1_to_s0");

        // R6: wrap the narrow counter by a long self-loop run
        for (int i = 0; i < 20; i++) step(1'b0, 2'b00, "R6_wrap");

        // R4: clear while the input is a self-loop for the present state
        step(1'b0, 2'b10, "R2_s0_to_s2");
        step(1'b1, 2'b10, "R4_clr_over_loop");
        step(1'b0, 2'b00, "R5_after_clr");

        // R7: seeded random stream with occasional clear
        for (int i = 0; i < 3000; i++) begin
            logic c;
            c = ($urandom % 64) == 0;
            step(c, 2'($urandom), "R7_random");
        end

        // R1: each output code reached directly
        step(1'b1, 2'b00, "R1_s0");
        step(1'b0, 2'b01, "R1_s1");
        step(1'b0, 2'b10, "R1_s2");
        step(1'b0, 2'b11, "R1_s3");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule